// File: doc/BRIEF.md
# Endian-Selectable Bus-Matching Converter

This block sits between a 36-bit long-word port and a narrow port that runs either 9 bits (byte size) or 18 bits (word size) wide. It has two independent paths. The unpack path takes one long word and hands it out as a series of narrow lanes. The pack path gathers narrow lanes and delivers them as one long word. Every side uses a valid/ready handshake. Storage and clock-domain crossing belong to the surrounding FIFO logic.

Two settings fix the lane order and the lane size: the endian select and the size select. Both are captured while the synchronous reset is high and are frozen when it drops. With big-endian order, the first narrow transfer maps to the most significant lane of the long word. With little-endian order, it maps to the least significant lane. Both paths follow the same rule. After reset, changing either setting input has no effect.

Top module: `bus_match_conv`

## Requirements
- R1: `cfg_big_endian` and `cfg_word_size` are sampled on every cycle that `rst` is high. The last sampled values govern both paths until the next reset. Changes after reset release are ignored.
- R2: In big-endian mode, unpacking emits the most significant lane first and the least significant lane last. In byte mode the order is bits [35:27], [26:18], [17:9], then [8:0].
- R3: In little-endian mode, unpacking emits the least significant lane first and the most significant lane last. In byte mode the order is bits [8:0], [17:9], [26:18], then [35:27].
- R4: Byte size (`cfg_word_size`=0) uses four 9-bit lanes. Those lanes travel in narrow bits [8:0], narrow output bits [17:9] read zero, and narrow input bits [17:9] are ignored. Word size (`cfg_word_size`=1) uses two 18-bit lanes, bits [35:18] and [17:0].
- R5: `up_nar_valid` follows `up_long_valid`. `up_long_ready` is high only in the cycle where the last lane of the current long word is accepted downstream (`up_nar_valid` and `up_nar_ready` both high).
- R6: In big-endian mode, packing places the first narrow item received in the most significant lane and the last item in the least significant lane.
- R7: In little-endian mode, packing places the first narrow item received in the least significant lane and the last item in the most significant lane.
- R8: `pk_long_valid` rises on the cycle after the last lane is accepted. It then holds, with `pk_long_data` stable, until the word is consumed. `pk_nar_ready` is low while the word is waiting to be consumed.
- R9: One cycle after a long word is consumed (`pk_long_valid` and `pk_long_ready` both high), `pk_long_valid` is low and the lane counter is back at zero. The next narrow item therefore lands in the first lane position.
- R10: After reset, `pk_long_valid` is 0, `pk_nar_ready` is 1, and both lane counters start at the first lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also the capture window for the settings |
| cfg_big_endian | input | 1 | Lane order select, 1 = big-endian, 0 = little-endian |
| cfg_word_size | input | 1 | Lane size select, 1 = 18-bit word, 0 = 9-bit byte |
| up_long_data | input | 36 | Long word to unpack |
| up_long_valid | input | 1 | Long word present |
| up_long_ready | output | 1 | Long word consumed (last lane taken) |
| up_nar_data | output | 18 | Current narrow lane |
| up_nar_valid | output | 1 | Narrow lane valid |
| up_nar_ready | input | 1 | Downstream takes the narrow lane |
| pk_nar_data | input | 18 | Narrow lane to pack |
| pk_nar_valid | input | 1 | Narrow lane present |
| pk_nar_ready | output | 1 | Packer can take a lane |
| pk_long_data | output | 36 | Assembled long word |
| pk_long_valid | output | 1 | Assembled word ready |
| pk_long_ready | input | 1 | Downstream takes the long word |

## Verification
The assertions assume that `up_long_data` holds steady while `up_long_valid` is high and has not yet been acknowledged. They also assume the setting inputs matter only during reset. The stimulus respects both: each long word is driven once, held through all of its lanes, and removed only after `up_long_ready`. The setting inputs are flipped only after reset release, to show they are ignored. The bench sweeps all four combinations of order and size. It inserts downstream stalls between lanes and holds the assembled word across an idle `pk_long_ready` cycle.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_WORD = 1'b1
  } lane_size_e;

  // Physical lane for transfer number k out of 'lanes'
  function automatic int lane_pos(input int k, input int lanes, input logic big_end);
    return big_end ? (lanes - 1 - k) : k;
  endfunction

endpackage

// File: rtl/bmc_cfg_latch.sv
module bmc_cfg_latch (
  input  logic             clk,
  input  logic             rst,
  input  logic             be_in,
  input  logic             word_in,
  output logic             be_q,
  output bmc_pkg::lane_size_e size_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      be_q   <= be_in;
      size_q <= word_in ? bmc_pkg::SZ_WORD : bmc_pkg::SZ_BYTE;
    end
  end
endmodule

// File: rtl/bmc_unpack.sv
module bmc_unpack #(
  parameter int LONG_W = 36,
  parameter int NAR_W  = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              big_end,
  input  bmc_pkg::lane_size_e size,
  input  logic [LONG_W-1:0] long_data,
  input  logic              long_valid,
  output logic              long_ready,
  output logic [NAR_W-1:0]  nar_data,
  output logic              nar_valid,
  input  logic              nar_ready
);
  localparam int BYTE_W      = NAR_W / 2;
  localparam int BYTE_LANES  = LONG_W / BYTE_W;
  localparam int WORD_LANES  = LONG_W / NAR_W;
  localparam int CW          = $clog2(BYTE_LANES);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic [CW-1:0] phys;
  logic          take;

  assign last = (size == bmc_pkg::SZ_WORD) ? CW'(WORD_LANES - 1) : CW'(BYTE_LANES - 1);
  assign phys = (size == bmc_pkg::SZ_WORD)
              ? CW'(bmc_pkg::lane_pos(int'(cnt), WORD_LANES, big_end))
              : CW'(bmc_pkg::lane_pos(int'(cnt), BYTE_LANES, big_end));

  assign nar_valid  = long_valid;
  assign take       = long_valid && nar_ready;
  assign long_ready = take && (cnt == last);

  always_comb begin
    nar_data = '0;
    if (size == bmc_pkg::SZ_WORD) begin
      for (int i = 0; i < WORD_LANES; i++)
        if (phys == CW'(i)) nar_data = long_data[i*NAR_W +: NAR_W];
    end else begin
      for (int i = 0; i < BYTE_LANES; i++)
        if (phys == CW'(i)) nar_data = {{(NAR_W-BYTE_W){1'b0}}, long_data[i*BYTE_W +: BYTE_W]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (take) cnt <= (cnt == last) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/bmc_pack.sv
module bmc_pack #(
  parameter int LONG_W = 36,
  parameter int NAR_W  = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              big_end,
  input  bmc_pkg::lane_size_e size,
  input  logic [NAR_W-1:0]  nar_data,
  input  logic              nar_valid,
  output logic              nar_ready,
  output logic [LONG_W-1:0] long_data,
  output logic              long_valid,
  input  logic              long_ready
);
  localparam int BYTE_W      = NAR_W / 2;
  localparam int BYTE_LANES  = LONG_W / BYTE_W;
  localparam int WORD_LANES  = LONG_W / NAR_W;
  localparam int CW          = $clog2(BYTE_LANES);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic [CW-1:0] phys;
  logic          take;

  assign last = (size == bmc_pkg::SZ_WORD) ? CW'(WORD_LANES - 1) : CW'(BYTE_LANES - 1);
  assign phys = (size == bmc_pkg::SZ_WORD)
              ? CW'(bmc_pkg::lane_pos(int'(cnt), WORD_LANES, big_end))
              : CW'(bmc_pkg::lane_pos(int'(cnt), BYTE_LANES, big_end));

  assign nar_ready = !long_valid;
  assign take      = nar_valid && nar_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      long_valid <= 1'b0;
      long_data  <= '0;
    end else begin
      if (take) begin
        if (size == bmc_pkg::SZ_WORD) begin
          for (int i = 0; i < WORD_LANES; i++)
            if (phys == CW'(i)) long_data[i*NAR_W +: NAR_W] <= nar_data;
        end else begin
          for (int i = 0; i < BYTE_LANES; i++)
            if (phys == CW'(i)) long_data[i*BYTE_W +: BYTE_W] <= nar_data[BYTE_W-1:0];
        end
        if (cnt == last) long_valid <= 1'b1;
        else             cnt        <= cnt + 1'b1;
      end
      if (long_valid && long_ready) begin
        long_valid <= 1'b0;
        cnt        <= '0;
      end
    end
  end
endmodule

// File: rtl/bus_match_conv.sv
module bus_match_conv #(
  parameter int LONG_W = 36,
  parameter int NAR_W  = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_big_endian,
  input  logic              cfg_word_size,
  input  logic [LONG_W-1:0] up_long_data,
  input  logic              up_long_valid,
  output logic              up_long_ready,
  output logic [NAR_W-1:0]  up_nar_data,
  output logic              up_nar_valid,
  input  logic              up_nar_ready,
  input  logic [NAR_W-1:0]  pk_nar_data,
  input  logic              pk_nar_valid,
  output logic              pk_nar_ready,
  output logic [LONG_W-1:0] pk_long_data,
  output logic              pk_long_valid,
  input  logic              pk_long_ready
);
  logic                be_q;
  bmc_pkg::lane_size_e size_q;

  bmc_cfg_latch u_cfg (
    .clk(clk), .rst(rst), .be_in(cfg_big_endian), .word_in(cfg_word_size),
    .be_q(be_q), .size_q(size_q)
  );

  bmc_unpack #(.LONG_W(LONG_W), .NAR_W(NAR_W)) u_unpack (
    .clk(clk), .rst(rst), .big_end(be_q), .size(size_q),
    .long_data(up_long_data), .long_valid(up_long_valid), .long_ready(up_long_ready),
    .nar_data(up_nar_data), .nar_valid(up_nar_valid), .nar_ready(up_nar_ready)
  );

  bmc_pack #(.LONG_W(LONG_W), .NAR_W(NAR_W)) u_pack (
    .clk(clk), .rst(rst), .big_end(be_q), .size(size_q),
    .nar_data(pk_nar_data), .nar_valid(pk_nar_valid), .nar_ready(pk_nar_ready),
    .long_data(pk_long_data), .long_valid(pk_long_valid), .long_ready(pk_long_ready)
  );
endmodule

// File: rtl/bmc_chk.sv
module bmc_chk #(
  parameter int LONG_W = 36,
  parameter int NAR_W  = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              be_q,
  input logic              size_q,
  input logic              up_long_valid,
  input logic              up_long_ready,
  input logic [NAR_W-1:0]  up_nar_data,
  input logic              up_nar_valid,
  input logic              up_nar_ready,
  input logic              pk_nar_ready,
  input logic [LONG_W-1:0] pk_long_data,
  input logic              pk_long_valid,
  input logic              pk_long_ready
);
  localparam int BYTE_W = NAR_W / 2;

  // R1
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(be_q) && $stable(size_q)));

  // R4
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!size_q && up_nar_valid) |-> (up_nar_data[NAR_W-1:BYTE_W] == '0));

  // R5
  long_ack_chk: assert property (@(posedge clk) disable iff (rst)
    up_long_ready |-> (up_nar_valid && up_nar_ready && up_long_valid));

  // R8
  pk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pk_long_valid && !pk_long_ready) |=> (pk_long_valid && $stable(pk_long_data)));

  // R8
  pk_backpressure_chk: assert property (@(posedge clk) disable iff (rst)
    pk_long_valid |-> !pk_nar_ready);

  // R9
  pk_release_chk: assert property (@(posedge clk) disable iff (rst)
    (pk_long_valid && pk_long_ready) |=> !pk_long_valid);

  // R10
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!pk_long_valid && pk_nar_ready));
endmodule

bind bus_match_conv bmc_chk #(.LONG_W(LONG_W), .NAR_W(NAR_W)) u_chk (
  .clk(clk), .rst(rst), .be_q(be_q), .size_q(size_q),
  .up_long_valid(up_long_valid), .up_long_ready(up_long_ready),
  .up_nar_data(up_nar_data), .up_nar_valid(up_nar_valid), .up_nar_ready(up_nar_ready),
  .pk_nar_ready(pk_nar_ready), .pk_long_data(pk_long_data),
  .pk_long_valid(pk_long_valid), .pk_long_ready(pk_long_ready)
);

// File: tb/test_bus_match_conv.sv
module test_bus_match_conv;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_big_endian = 1'b0;
  logic        cfg_word_size = 1'b0;
  logic [35:0] up_long_data = '0;
  logic        up_long_valid = 1'b0;
  logic        up_long_ready;
  logic [17:0] up_nar_data;
  logic        up_nar_valid;
  logic        up_nar_ready = 1'b0;
  logic [17:0] pk_nar_data = '0;
  logic        pk_nar_valid = 1'b0;
  logic        pk_nar_ready;
  logic [35:0] pk_long_data;
  logic        pk_long_valid;
  logic        pk_long_ready = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  bus_match_conv i_bus_match_conv (.*);

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] lane_mask(bit word);
    return word ? 36'h3FFFF : 36'h001FF;
  endfunction

  function automatic int lane_bits(bit word);
    return word ? 18 : 9;
  endfunction

  function automatic int lane_cnt(bit word);
    return word ? 2 : 4;
  endfunction

  function automatic int phys_of(int k, bit be, bit word);
    return be ? lane_cnt(word) - 1 - k : k;
  endfunction

  task automatic do_reset(input bit be, input bit word);
    @(negedge clk);
    rst = 1'b1; cfg_big_endian = be; cfg_word_size = word;
    up_long_valid = 1'b0; up_nar_ready = 1'b0; pk_nar_valid = 1'b0; pk_long_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // flip the setting inputs after release: must be ignored (R1)
    cfg_big_endian = ~be; cfg_word_size = ~word;
    #1;
    chk(pk_long_valid == 1'b0, "R10 pk_long_valid after reset", 36'(pk_long_valid), 36'h0);
    chk(pk_nar_ready == 1'b1, "R10 pk_nar_ready after reset", 36'(pk_nar_ready), 36'h1);
    chk(up_long_ready == 1'b0, "R5 no ack while idle", 36'(up_long_ready), 36'h0);
  endtask

  task automatic unpack_word(input bit be, input bit word, input int seed);
    logic [35:0] w;
    logic [35:0] exp;
    string rq;
    w = 36'h123456789 ^ (36'(seed) * 36'h913579BDF);
    rq = be ? "R2/R1 unpack big-endian" : "R3/R1 unpack little-endian";
    @(negedge clk);
    up_long_data = w; up_long_valid = 1'b1;
    for (int k = 0; k < lane_cnt(word); k++) begin
      exp = (w >> (phys_of(k, be, word) * lane_bits(word))) & lane_mask(word);
      if (((seed + k) % 2) == 1) begin
        up_nar_ready = 1'b0;
        #1;
        chk(up_nar_valid == 1'b1, "R5 narrow valid follows long valid", 36'(up_nar_valid), 36'h1);
        chk(up_long_ready == 1'b0, "R5 no ack during stall", 36'(up_long_ready), 36'h0);
        chk(36'(up_nar_data) == exp, rq, 36'(up_nar_data), exp);
        @(negedge clk);
      end
      up_nar_ready = 1'b1;
      #1;
      chk(36'(up_nar_data) == exp, rq, 36'(up_nar_data), exp);
      if (!word)
        chk(up_nar_data[17:9] == 9'h0, "R4 byte mode upper bits zero", 36'(up_nar_data), exp);
      chk(up_long_ready == (k == lane_cnt(word) - 1), "R5 ack only on last lane",
          36'(up_long_ready), 36'(k == lane_cnt(word) - 1));
      @(negedge clk);
    end
    up_long_valid = 1'b0; up_nar_ready = 1'b0;
  endtask

  task automatic pack_word(input bit be, input bit word, input int seed);
    logic [35:0] exp;
    logic [35:0] item;
    string rq;
    exp = '0;
    rq = be ? "R6/R9 pack big-endian" : "R7/R9 pack little-endian";
    for (int k = 0; k < lane_cnt(word); k++) begin
      item = 36'(seed * 97 + k * 53 + 5) & lane_mask(word);
      exp = exp | (item << (phys_of(k, be, word) * lane_bits(word)));
      @(negedge clk);
      // in byte mode, garbage in upper bits must be ignored (R4)
      pk_nar_data = word ? item[17:0] : {9'h1FF, item[8:0]};
      pk_nar_valid = 1'b1;
      #1;
      chk(pk_nar_ready == 1'b1, "R8 ready while collecting", 36'(pk_nar_ready), 36'h1);
      chk(pk_long_valid == 1'b0, "R8 no early long valid", 36'(pk_long_valid), 36'h0);
    end
    @(negedge clk);
    pk_nar_valid = 1'b0; pk_nar_data = '0;
    #1;
    chk(pk_long_valid == 1'b1, "R8 long valid after last lane", 36'(pk_long_valid), 36'h1);
    chk(pk_long_data == exp, rq, pk_long_data, exp);
    chk(pk_nar_ready == 1'b0, "R8 narrow ready low while pending", 36'(pk_nar_ready), 36'h0);
    // try to push while pending: must not be taken
    pk_nar_valid = 1'b1; pk_nar_data = 18'h3FFFF;
    @(negedge clk);
    pk_nar_valid = 1'b0;
    #1;
    chk(pk_long_valid == 1'b1 && pk_long_data == exp, "R8 word held while not consumed", pk_long_data, exp);
    pk_long_ready = 1'b1;
    @(negedge clk);
    pk_long_ready = 1'b0;
    #1;
    chk(pk_long_valid == 1'b0, "R9 valid drops after consume", 36'(pk_long_valid), 36'h0);
    chk(pk_nar_ready == 1'b1, "R9 ready again after consume", 36'(pk_nar_ready), 36'h1);
  endtask

  initial begin
    for (int c = 0; c < 4; c++) begin
      do_reset(c[0], c[1]);
      for (int s = 0; s < 4; s++) unpack_word(c[0], c[1], s + c * 4);
      for (int s = 0; s < 4; s++) pack_word(c[0], c[1], s + c * 4);
    end
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule